// File: doc/BRIEF.md
# PSRAM Refresh and Power-Up Scheduler

This block keeps a pseudo-static RAM alive whenever no access is in flight. After reset it waits out the supply settling time. It then issues a train of dummy chip-enable cycles and raises `ready`. From then on it spaces single refresh pulses evenly over the retention period. Each pulse is a low level on the shared output-enable/refresh line while chip enable stays high. All timing is counted in clock cycles and set by parameters.

An access sequencer asks for the bus with `accessReq`. It owns the bus while `accessGrant` is high, and it gives the bus back by dropping the request. A refresh that falls due during an access is held in a pending flag and is issued once the command delay after the access has elapsed. A low-power request drives the refresh line low long enough to put the RAM into self refresh. `lowPowerAck` confirms that self refresh has been entered. When the request is released, both controls are kept high through a reset window. A catch-up refresh follows directly after that window.

Top module: `psram_refresh_sched`

## Requirements
- R1: While reset is asserted, `ceN`=1, `oeRfshN`=1, `ready`=0, `accessGrant`=0, `lowPowerAck`=0 and `busy`=1.
- R2: The first `ceN` fall happens exactly POWERUP_CYC cycles after reset release. It is followed by INIT_CYCLES low pulses on `ceN`, each DUMMY_LOW_CYC cycles wide and separated by at least DUMMY_HIGH_CYC high cycles. `ready` rises exactly POWERUP_CYC + INIT_CYCLES*(DUMMY_LOW_CYC+DUMMY_HIGH_CYC) cycles after reset release.
- R3: Before `ready` is high, `accessReq` and `lowPowerReq` are ignored: `accessGrant` and `lowPowerAck` stay 0 and `oeRfshN` stays 1.
- R4: Each automatic refresh drives `oeRfshN` low for exactly AUTO_LOW_CYC cycles. `ceN` stays high throughout, and at least PRECH_CYC high cycles on `oeRfshN` come before the pulse.
- R5: With no access and no low-power request, consecutive automatic refresh falls are exactly REF_INTERVAL_CYC cycles apart.
- R6: When the block is ready, idle and has no refresh pending, `accessGrant` rises one cycle after `accessReq`. While granted, `busy`=0 and `ceN`=`oeRfshN`=1. `accessGrant` falls one cycle after `accessReq` drops.
- R7: A refresh that falls due during a grant is not issued during the grant and is not lost. Its `oeRfshN` fall comes between CMD_DELAY_CYC+PRECH_CYC and CMD_DELAY_CYC+PRECH_CYC+3 cycles after `accessReq` drops.
- R8: When `lowPowerReq` is raised while the block is idle, `oeRfshN` goes low and stays low while the request is held. `lowPowerAck` rises exactly SELF_ENTER_CYC cycles after that fall, and `ceN` stays high throughout.
- R9: When `lowPowerReq` drops, `lowPowerAck` falls one cycle later. `oeRfshN` then stays high for at least EXIT_CYC cycles. The catch-up refresh falls no later than EXIT_CYC+PRECH_CYC+3 cycles after the drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every timing parameter is counted in its cycles |
| rstN | input | 1 | Active-low synchronous reset |
| lowPowerReq | input | 1 | Request to enter and hold self refresh |
| accessReq | input | 1 | Access sequencer asks for the memory bus |
| ceN | output | 1 | Chip enable (active low) while the scheduler holds the bus |
| oeRfshN | output | 1 | Output-enable/refresh line while the scheduler holds the bus |
| accessGrant | output | 1 | Bus handed to the access sequencer |
| busy | output | 1 | Scheduler is in the middle of initialisation, a refresh or self refresh |
| ready | output | 1 | Initialisation complete; accesses may be granted |
| lowPowerAck | output | 1 | Self refresh has been entered |

## Verification
Every result has a fixed cycle count behind it. The grant changes one cycle after the request moves. `ready` and the first dummy fall land at exact edge counts after reset release. A deferred refresh lands six cycles after release of the request. The post-self-refresh refresh lands EXIT_CYC+PRECH_CYC+2 cycles after the low-power request drops. The bench counts rising edges from reset release and samples on falling edges. A monitor stamps every fall and rise of `ceN` and `oeRfshN` with that count. Distances between events are compared with these exact values, or with the bounded windows the requirements allow. Each measured pulse width and preceding high time is checked against a queue of expected pulses that the driver fills before each stimulus.

// File: rtl/psram_sched_pkg.sv
package psram_sched_pkg;

  localparam int WAIT_W = 16;

  typedef enum logic [3:0] {
    ST_PWRWAIT,
    ST_DUMMY_LOW,
    ST_DUMMY_HIGH,
    ST_IDLE,
    ST_PRECH,
    ST_RF_LOW,
    ST_RF_RECOV,
    ST_GRANT,
    ST_POSTACC,
    ST_SELF_PRE,
    ST_SELF_LOW,
    ST_SELF_HOLD,
    ST_SELF_EXIT
  } sched_state_t;

  typedef struct packed {
    logic              loadWait;
    logic [WAIT_W-1:0] waitVal;
    logic              timerRun;
    logic              timerRestart;
    logic              setPending;
    logic              clearPending;
    logic              dummyInc;
  } sched_strobe_t;

endpackage

// File: rtl/psram_refresh_dp.sv
module psram_refresh_dp
  import psram_sched_pkg::*;
#(
  parameter int POWERUP_CYC      = 5000,
  parameter int INIT_CYCLES      = 8,
  parameter int REF_INTERVAL_CYC = 780
) (
  input  logic          clk,
  input  logic          rstN,
  input  sched_strobe_t strobes,
  output logic          waitDone,
  output logic          refreshPending,
  output logic          dummyLast
);

  localparam int REF_W = $clog2(REF_INTERVAL_CYC + 1);
  localparam int DUM_W = $clog2(INIT_CYCLES + 1);

  logic [WAIT_W-1:0] waitCnt;
  logic [REF_W-1:0]  refCnt;
  logic [DUM_W-1:0]  dummyCnt;
  logic              timerWrap;

  // General wait counter: loading N keeps waitDone low for N-1 cycles
  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= WAIT_W'(POWERUP_CYC - 1);
    end else if (strobes.loadWait) begin
      waitCnt <= strobes.waitVal - WAIT_W'(1);
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - WAIT_W'(1);
    end
  end

  assign waitDone = (waitCnt == '0);

  // Distributed refresh interval timer
  assign timerWrap = strobes.timerRun && (refCnt == REF_W'(REF_INTERVAL_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt <= '0;
    end else if (!strobes.timerRun || strobes.timerRestart || timerWrap) begin
      refCnt <= '0;
    end else begin
      refCnt <= refCnt + REF_W'(1);
    end
  end

  // Pending refresh flag; a new due refresh wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refreshPending <= 1'b0;
    end else if (timerWrap || strobes.setPending) begin
      refreshPending <= 1'b1;
    end else if (strobes.clearPending) begin
      refreshPending <= 1'b0;
    end
  end

  // Dummy cycle counter for the power-up train
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dummyCnt <= '0;
    end else if (strobes.dummyInc) begin
      dummyCnt <= dummyCnt + DUM_W'(1);
    end
  end

  assign dummyLast = (dummyCnt == DUM_W'(INIT_CYCLES - 1));

endmodule

// File: rtl/psram_refresh_ctrl.sv
module psram_refresh_ctrl
  import psram_sched_pkg::*;
#(
  parameter int DUMMY_LOW_CYC  = 4,
  parameter int DUMMY_HIGH_CYC = 3,
  parameter int PRECH_CYC      = 2,
  parameter int AUTO_LOW_CYC   = 4,
  parameter int RECOV_CYC      = 2,
  parameter int CMD_DELAY_CYC  = 2,
  parameter int SELF_ENTER_CYC = 420,
  parameter int EXIT_CYC       = 31
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          lowPowerReq,
  input  logic          accessReq,
  input  logic          waitDone,
  input  logic          refreshPending,
  input  logic          dummyLast,
  output sched_strobe_t strobes,
  output logic          ceN,
  output logic          oeRfshN,
  output logic          ready,
  output logic          accessGrant,
  output logic          lowPowerAck,
  output logic          busy
);

  sched_state_t state, nextState;
  logic         inSelf;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_PWRWAIT;
    else       state <= nextState;
  end

  assign ready  = !(state inside {ST_PWRWAIT, ST_DUMMY_LOW, ST_DUMMY_HIGH});
  assign inSelf = state inside {ST_SELF_PRE, ST_SELF_LOW, ST_SELF_HOLD, ST_SELF_EXIT};

  always_comb begin
    nextState        = state;
    strobes          = '0;
    strobes.timerRun = ready && !inSelf;
    unique case (state)
      ST_PWRWAIT: if (waitDone) begin
        nextState        = ST_DUMMY_LOW;
        strobes.loadWait = 1'b1;
        strobes.waitVal  = WAIT_W'(DUMMY_LOW_CYC);
      end
      ST_DUMMY_LOW: if (waitDone) begin
        nextState        = ST_DUMMY_HIGH;
        strobes.loadWait = 1'b1;
        strobes.waitVal  = WAIT_W'(DUMMY_HIGH_CYC);
      end
      ST_DUMMY_HIGH: if (waitDone) begin
        if (dummyLast) begin
          nextState = ST_IDLE;
        end else begin
          nextState        = ST_DUMMY_LOW;
          strobes.loadWait = 1'b1;
          strobes.waitVal  = WAIT_W'(DUMMY_LOW_CYC);
          strobes.dummyInc = 1'b1;
        end
      end
      ST_IDLE: begin
        if (refreshPending) begin
          nextState        = ST_PRECH;
          strobes.loadWait = 1'b1;
          strobes.waitVal  = WAIT_W'(PRECH_CYC);
        end else if (lowPowerReq) begin
          nextState        = ST_SELF_PRE;
          strobes.loadWait = 1'b1;
          strobes.waitVal  = WAIT_W'(PRECH_CYC);
        end else if (accessReq) begin
          nextState = ST_GRANT;
        end
      end
      ST_PRECH: if (waitDone) begin
        nextState            = ST_RF_LOW;
        strobes.loadWait     = 1'b1;
        strobes.waitVal      = WAIT_W'(AUTO_LOW_CYC);
        strobes.clearPending = 1'b1;
      end
      ST_RF_LOW: if (waitDone) begin
        nextState        = ST_RF_RECOV;
        strobes.loadWait = 1'b1;
        strobes.waitVal  = WAIT_W'(RECOV_CYC);
      end
      ST_RF_RECOV: if (waitDone) nextState = ST_IDLE;
      ST_GRANT: if (!accessReq) begin
        nextState        = ST_POSTACC;
        strobes.loadWait = 1'b1;
        strobes.waitVal  = WAIT_W'(CMD_DELAY_CYC);
      end
      ST_POSTACC: if (waitDone) nextState = ST_IDLE;
      ST_SELF_PRE: if (waitDone) begin
        nextState        = ST_SELF_LOW;
        strobes.loadWait = 1'b1;
        strobes.waitVal  = WAIT_W'(SELF_ENTER_CYC);
      end
      ST_SELF_LOW: if (waitDone) nextState = ST_SELF_HOLD;
      ST_SELF_HOLD: if (!lowPowerReq) begin
        nextState        = ST_SELF_EXIT;
        strobes.loadWait = 1'b1;
        strobes.waitVal  = WAIT_W'(EXIT_CYC);
      end
      ST_SELF_EXIT: if (waitDone) begin
        nextState            = ST_IDLE;
        strobes.setPending   = 1'b1;
        strobes.timerRestart = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign ceN         = (state != ST_DUMMY_LOW);
  assign oeRfshN     = !(state inside {ST_RF_LOW, ST_SELF_LOW, ST_SELF_HOLD});
  assign accessGrant = (state == ST_GRANT);
  assign lowPowerAck = (state == ST_SELF_HOLD);
  assign busy        = !(state inside {ST_IDLE, ST_GRANT});

  // R6: the bus comes back one cycle after the sequencer lets go
  a_r6_grant_drop: assert property (@(posedge clk) disable iff (!rstN)
    (accessGrant && !accessReq) |=> !accessGrant);

endmodule

// File: rtl/psram_refresh_sched.sv
module psram_refresh_sched
  import psram_sched_pkg::*;
#(
  parameter int POWERUP_CYC      = 5000,
  parameter int INIT_CYCLES      = 8,
  parameter int DUMMY_LOW_CYC    = 4,
  parameter int DUMMY_HIGH_CYC   = 3,
  parameter int REF_INTERVAL_CYC = 780,
  parameter int PRECH_CYC        = 2,
  parameter int AUTO_LOW_CYC     = 4,
  parameter int RECOV_CYC        = 2,
  parameter int CMD_DELAY_CYC    = 2,
  parameter int SELF_ENTER_CYC   = 420,
  parameter int EXIT_CYC         = 31
) (
  input  logic clk,
  input  logic rstN,
  input  logic lowPowerReq,
  input  logic accessReq,
  output logic ceN,
  output logic oeRfshN,
  output logic accessGrant,
  output logic busy,
  output logic ready,
  output logic lowPowerAck
);

  sched_strobe_t strobes;
  logic          waitDone;
  logic          refreshPending;
  logic          dummyLast;

  psram_refresh_dp #(
    .POWERUP_CYC     (POWERUP_CYC),
    .INIT_CYCLES     (INIT_CYCLES),
    .REF_INTERVAL_CYC(REF_INTERVAL_CYC)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .waitDone      (waitDone),
    .refreshPending(refreshPending),
    .dummyLast     (dummyLast)
  );

  psram_refresh_ctrl #(
    .DUMMY_LOW_CYC (DUMMY_LOW_CYC),
    .DUMMY_HIGH_CYC(DUMMY_HIGH_CYC),
    .PRECH_CYC     (PRECH_CYC),
    .AUTO_LOW_CYC  (AUTO_LOW_CYC),
    .RECOV_CYC     (RECOV_CYC),
    .CMD_DELAY_CYC (CMD_DELAY_CYC),
    .SELF_ENTER_CYC(SELF_ENTER_CYC),
    .EXIT_CYC      (EXIT_CYC)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .lowPowerReq   (lowPowerReq),
    .accessReq     (accessReq),
    .waitDone      (waitDone),
    .refreshPending(refreshPending),
    .dummyLast     (dummyLast),
    .strobes       (strobes),
    .ceN           (ceN),
    .oeRfshN       (oeRfshN),
    .ready         (ready),
    .accessGrant   (accessGrant),
    .lowPowerAck   (lowPowerAck),
    .busy          (busy)
  );

  // Run-length counters watching the pins, for the timing properties below
  localparam int CHK_W = 16;
  logic [CHK_W-1:0] oeLowRun, oeHighRun, ceLowRun;
  logic             prevAck, exitArmed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oeLowRun  <= '0;
      oeHighRun <= '0;
      ceLowRun  <= '0;
      prevAck   <= 1'b0;
      exitArmed <= 1'b0;
    end else begin
      prevAck   <= lowPowerAck;
      oeLowRun  <= oeRfshN ? '0 : ((oeLowRun == '1) ? oeLowRun : oeLowRun + CHK_W'(1));
      oeHighRun <= !oeRfshN ? '0 : ((oeHighRun == '1) ? oeHighRun : oeHighRun + CHK_W'(1));
      ceLowRun  <= ceN ? '0 : ((ceLowRun == '1) ? ceLowRun : ceLowRun + CHK_W'(1));
      if (prevAck && !lowPowerAck) exitArmed <= 1'b1;
      else if (!oeRfshN)           exitArmed <= 1'b0;
    end
  end

  // R2: every dummy chip-enable pulse has the programmed width
  a_r2_dummy_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ceN) |-> ceLowRun == CHK_W'(DUMMY_LOW_CYC));

  // R4: no refresh-line low pulse is shorter than the minimum
  a_r4_pulse_min: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oeRfshN) |-> oeLowRun >= CHK_W'(AUTO_LOW_CYC));

  // R4: precharge high time ahead of each refresh-line fall
  a_r4_precharge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oeRfshN) |-> oeHighRun >= CHK_W'(PRECH_CYC));

  // R3: the bus is only handed out once initialisation has finished
  a_r3_grant_after_ready: assert property (@(posedge clk) disable iff (!rstN)
    accessGrant |-> ready);

  // R8: acknowledge only while the line is held low with chip enable high
  a_r8_ack_in_self: assert property (@(posedge clk) disable iff (!rstN)
    lowPowerAck |-> (!oeRfshN && ceN));

  // R9: reset window after self refresh before the next fall
  a_r9_exit_window: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(oeRfshN) && exitArmed) |-> oeHighRun >= CHK_W'(EXIT_CYC));

endmodule

// File: tb/psram_refresh_sched_bench.sv
module psram_refresh_sched_bench;

  localparam int P    = 5000;
  localparam int INIT = 8;
  localparam int L    = 4;
  localparam int H    = 3;
  localparam int IVL  = 780;
  localparam int PRE  = 2;
  localparam int ALOW = 4;
  localparam int CMD  = 2;
  localparam int SELF = 420;
  localparam int EXIT = 31;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lowPowerReq = 1'b0;
  logic accessReq = 1'b0;
  logic ceN, oeRfshN, accessGrant, busy, ready, lowPowerAck;

  always #10 clk = ~clk;

  psram_refresh_sched u_psram_refresh_sched (
    .clk(clk), .rstN(rstN), .lowPowerReq(lowPowerReq), .accessReq(accessReq),
    .ceN(ceN), .oeRfshN(oeRfshN), .accessGrant(accessGrant), .busy(busy),
    .ready(ready), .lowPowerAck(lowPowerAck)
  );

  int edgeCnt = 0;
  always @(posedge clk) if (rstN) edgeCnt++;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard: expected pulses {preceding high minimum, width min, width max}
  typedef struct { int preMin; int minW; int maxW; } pulse_t;
  pulse_t ceQ[$];
  pulse_t oeQ[$];
  string  ceTag[$];
  string  oeTag[$];

  task automatic expectPulse(input bit isOe, input int preMin, input int mn, input int mx, input string tag);
    pulse_t p;
    p.preMin = preMin; p.minW = mn; p.maxW = mx;
    if (isOe) begin oeQ.push_back(p); oeTag.push_back(tag); end
    else      begin ceQ.push_back(p); ceTag.push_back(tag); end
  endtask

  // Monitor
  logic prevCe = 1'b1, prevOe = 1'b1;
  int ceLow = 0, ceHigh = 0, oeLow = 0, oeHigh = 0;
  int firstCeFall = -1, lastOeFall = 0, prevOeFall = 0;
  int oeFalls = 0, oeRises = 0;

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (!ceN && prevCe) begin
        if (firstCeFall < 0) firstCeFall = edgeCnt;
        if (ceQ.size() == 0) check(1'b0, "R2 unexpected ceN pulse", 1, 0);
        else check(ceHigh >= ceQ[0].preMin, {ceTag[0], " ceN high before pulse"}, ceHigh, ceQ[0].preMin);
        ceLow = 0;
      end
      if (ceN && !prevCe && ceQ.size() > 0) begin
        check(ceLow >= ceQ[0].minW && ceLow <= ceQ[0].maxW, {ceTag[0], " ceN low width"}, ceLow, ceQ[0].minW);
        void'(ceQ.pop_front());
        void'(ceTag.pop_front());
        ceHigh = 0;
      end
      if (!oeRfshN && prevOe) begin
        prevOeFall = lastOeFall;
        lastOeFall = edgeCnt;
        oeFalls++;
        if (oeQ.size() == 0) check(1'b0, "R4 unexpected oeRfshN pulse", 1, 0);
        else check(oeHigh >= oeQ[0].preMin, {oeTag[0], " oeRfshN high before pulse"}, oeHigh, oeQ[0].preMin);
        oeLow = 0;
      end
      if (oeRfshN && !prevOe) begin
        oeRises++;
        if (oeQ.size() > 0) begin
          check(oeLow >= oeQ[0].minW && oeLow <= oeQ[0].maxW, {oeTag[0], " oeRfshN low width"}, oeLow, oeQ[0].minW);
          void'(oeQ.pop_front());
          void'(oeTag.pop_front());
        end
        oeHigh = 0;
      end
      if (!oeRfshN && !ceN) check(1'b0, "R4 ceN low while oeRfshN low", 0, 1);
      if (!ceN) ceLow++; else ceHigh++;
      if (!oeRfshN) oeLow++; else oeHigh++;
      prevCe = ceN;
      prevOe = oeRfshN;
    end
  end

  task automatic finishUp();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", edgeCnt, 0);
    finishUp();
  end

  initial begin
    int t0;
    int f0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(ceN === 1'b1 && oeRfshN === 1'b1, "R1 pins high in reset", {ceN, oeRfshN}, 3);
    check(ready === 1'b0 && accessGrant === 1'b0 && lowPowerAck === 1'b0, "R1 flags low in reset",
          {ready, accessGrant, lowPowerAck}, 0);
    check(busy === 1'b1, "R1 busy in reset", busy, 1);
    for (int i = 0; i < INIT; i++) expectPulse(1'b0, H, L, L, "R2");
    rstN = 1'b1;

    // R3: requests ignored during initialisation
    while (edgeCnt < 100) @(negedge clk);
    accessReq = 1'b1;
    lowPowerReq = 1'b1;
    while (edgeCnt < 200) @(negedge clk);
    check(accessGrant == 1'b0, "R3 grant before ready", accessGrant, 0);
    check(lowPowerAck == 1'b0, "R3 ack before ready", lowPowerAck, 0);
    check(oeRfshN == 1'b1, "R3 refresh line before ready", oeRfshN, 1);
    accessReq = 1'b0;
    lowPowerReq = 1'b0;

    // R2: ready timing and first dummy fall
    while (!ready) @(negedge clk);
    check(edgeCnt == P + INIT * (L + H), "R2 ready time", edgeCnt, P + INIT * (L + H));
    check(firstCeFall == P, "R2 first dummy fall", firstCeFall, P);
    check(ceQ.size() == 0, "R2 dummy pulse count", ceQ.size(), 0);

    // R4, R5: two distributed refreshes while idle
    expectPulse(1'b1, PRE, ALOW, ALOW, "R4");
    expectPulse(1'b1, PRE, ALOW, ALOW, "R5");
    while (oeRises < 2) @(negedge clk);
    check(lastOeFall - prevOeFall == IVL, "R5 refresh spacing", lastOeFall - prevOeFall, IVL);

    // R6, R7: long access with a refresh falling due inside it
    repeat (3) @(negedge clk);
    accessReq = 1'b1;
    @(negedge clk);
    check(accessGrant == 1'b1, "R6 grant one cycle after request", accessGrant, 1);
    check(busy == 1'b0 && ceN == 1'b1 && oeRfshN == 1'b1, "R6 bus released while granted",
          {busy, ceN, oeRfshN}, 3);
    f0 = oeFalls;
    expectPulse(1'b1, PRE, ALOW, ALOW, "R7");
    repeat (2 * IVL) @(negedge clk);
    check(oeFalls == f0, "R7 no refresh during grant", oeFalls - f0, 0);
    check(accessGrant == 1'b1, "R6 grant held with request", accessGrant, 1);
    accessReq = 1'b0;
    t0 = edgeCnt;
    @(negedge clk);
    check(accessGrant == 1'b0, "R6 grant drops one cycle after request", accessGrant, 0);
    while (oeFalls == f0) @(negedge clk);
    check(lastOeFall - t0 >= CMD + PRE && lastOeFall - t0 <= CMD + PRE + 3, "R7 deferred refresh delay",
          lastOeFall - t0, CMD + PRE + 2);
    while (oeRises < 3) @(negedge clk);

    // R8: self refresh entry
    repeat (3) @(negedge clk);
    lowPowerReq = 1'b1;
    expectPulse(1'b1, PRE, SELF, 100000, "R8");
    while (!lowPowerAck) @(negedge clk);
    check(edgeCnt - lastOeFall == SELF, "R8 ack delay after fall", edgeCnt - lastOeFall, SELF);
    check(oeRfshN == 1'b0 && ceN == 1'b1, "R8 pins in self refresh", {ceN, oeRfshN}, 2);
    repeat (1000) @(negedge clk);
    check(lowPowerAck == 1'b1 && oeRfshN == 1'b0, "R8 self refresh held", {lowPowerAck, oeRfshN}, 2);

    // R9: self refresh exit and catch-up refresh
    f0 = oeFalls;
    lowPowerReq = 1'b0;
    t0 = edgeCnt;
    expectPulse(1'b1, EXIT, ALOW, ALOW, "R9");
    @(negedge clk);
    check(lowPowerAck == 1'b0, "R9 ack drops", lowPowerAck, 0);
    check(oeRfshN == 1'b1, "R9 line high in exit window", oeRfshN, 1);
    while (oeFalls == f0) @(negedge clk);
    check(lastOeFall - t0 >= EXIT && lastOeFall - t0 <= EXIT + PRE + 3, "R9 catch-up refresh delay",
          lastOeFall - t0, EXIT + PRE + 2);
    while (oeRises < 5) @(negedge clk);
    check(oeQ.size() == 0, "R4 all expected refresh pulses seen", oeQ.size(), 0);
    repeat (5) @(negedge clk);
    finishUp();
  end

endmodule